// File: doc/BRIEF.md
# Two-Channel High/Low Count Pulse-Width Modulator

This block drives two pulse-width modulated output pins from one input clock. Each channel is described by two counts: how many prescaled ticks the pin stays high and how many ticks it then stays low. The period is the sum of the two counts. Each channel has its own prescaler, which turns the input clock into a slower tick stream. Each channel is switched on by two separate enable bits, and both must be set.

Software reaches the block through a small 32-bit register port with a write strobe, a read strobe, a word address and data. There are three words: one timing word per channel and one shared control word. A new timing value written while a channel runs is held back until the running period ends. This means a half-finished phase is never cut short or stretched.

Top module: `pwm_hl_dual`

## Requirements
- R1: After reset every register reads zero and both outputs are low.
- R2: Word 0 is channel A timing, word 1 is channel B timing and word 2 is the control word. A read strobe returns the addressed word's stored value on `rdata` in the cycle after the strobe, and `rdata` holds until the next read. Word 3 always reads zero, and writes to it change nothing.
- R3: In a timing word, bits 31:16 give the high count H and bits 15:0 give the low count L. Every period is H high ticks followed by L low ticks, so the period is H+L ticks.
- R4: Control bits 14:8 hold channel A's prescaler value D and bits 22:16 hold channel B's. A running channel advances one tick every D+1 input clocks, so the divide range is 1 to 128.
- R5: Channel A runs only while control bit 15 (clock enable) and bit 0 (run enable) are both 1. Channel B uses bits 23 and 1. Otherwise its output is low and its prescaler and period position are cleared.
- R6: When the control write that starts a channel is captured at a clock edge, the output in the n-th clock interval after that edge (n = 0, 1, ...) is high exactly when (floor(n/(D+1)) mod (H+L)) < H.
- R7: H = 0 gives a constantly low output. L = 0 with H > 0 gives a constantly high output. H = L = 0 gives a low output.
- R8: A timing word written while its channel runs takes effect only from the next period start. The period in progress finishes with its old counts.
- R9: The two channels are independent. A channel's output never depends on the other channel's timing word or control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock for the register file and both prescalers |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, captured at the rising edge |
| rd_en | input | 1 | Read strobe, returns data on the next cycle |
| addr | input | 2 | Word address (0 A timing, 1 B timing, 2 control) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_o | output | 2 | Output pins, bit 0 channel A, bit 1 channel B |

## Verification
Read data is due one cycle after the read strobe. A channel's output answers in the same clock interval that follows the edge capturing its control write, and then moves one position every D+1 clocks. A running timing change shows up only at the interval that starts the next period. The bench drives inputs and samples outputs on the falling edge. It counts intervals from the edge that captured the enabling write and computes each expected pin level from the formula for that interval index. For a timing change it counts up to the old period's end and then switches to the new counts.

// File: rtl/pwm_hl_pkg.sv
package pwm_hl_pkg;
   localparam int WORD_W   = 32;
   localparam int NUM_CH   = 2;
   localparam int CTRL_IDX = NUM_CH;
   localparam int HIGH_LSB = 16;
   localparam int LOW_LSB  = 0;
   localparam int FIELD_W  = 16;
   localparam int DIV_MAXW = 7;

   function automatic int div_lsb(input int ch);
      return 8 + 8 * ch;
   endfunction

   function automatic int clken_bit(input int ch);
      return 15 + 8 * ch;
   endfunction

   function automatic int run_bit(input int ch);
      return ch;
   endfunction
endpackage

// File: rtl/pwm_hl_regs.sv
module pwm_hl_regs
   import pwm_hl_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic                             rd_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [WORD_W-1:0]                wdata,
   output logic [WORD_W-1:0]                rdata,
   output logic [NUM_CH-1:0][WORD_W-1:0]    time_q,
   output logic [WORD_W-1:0]                ctl_q
);
   logic [WORD_W-1:0] rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '0;
         ctl_q  <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) time_q[i] <= wdata;
         end
         if (addr == ADDR_W'(CTRL_IDX)) ctl_q <= wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(i)) rd_mux = time_q[i];
      end
      if (addr == ADDR_W'(CTRL_IDX)) rd_mux = ctl_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end
endmodule

// File: rtl/pwm_hl_prescale.sv
module pwm_hl_prescale #(
   parameter int DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = active && (cnt_q == div);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) cnt_q <= '0;
      else if (tick)         cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pwm_hl_wave.sv
module pwm_hl_wave #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic [CNT_W-1:0] hi_in,
   input  logic [CNT_W-1:0] lo_in,
   output logic             pwm
);
   localparam int POS_W = CNT_W + 1;

   logic [CNT_W-1:0] hi_cur, lo_cur;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] span;
   logic             last;

   assign span = {1'b0, hi_cur} + {1'b0, lo_cur};
   assign last = (span == '0) || (pos_q == span - 1'b1);
   assign pwm  = active && (pos_q < {1'b0, hi_cur});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_cur <= '0;
         lo_cur <= '0;
         pos_q  <= '0;
      end else if (!active) begin
         hi_cur <= hi_in;
         lo_cur <= lo_in;
         pos_q  <= '0;
      end else if (tick) begin
         if (last) begin
            hi_cur <= hi_in;
            lo_cur <= lo_in;
            pos_q  <= '0;
         end else begin
            pos_q  <= pos_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwm_hl_dual.sv
module pwm_hl_dual
   import pwm_hl_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DIV_W  = 7,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [1:0]        pwm_o
);
   if (CNT_W < 1 || CNT_W > FIELD_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end
   if (DIV_W < 1 || DIV_W > DIV_MAXW) begin : g_bad_div
      $error("DIV_W must lie in 1..7");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic [NUM_CH-1:0][WORD_W-1:0] time_q;
   logic [WORD_W-1:0]             ctl_q;
   logic [NUM_CH-1:0]             tick_w;
   logic [NUM_CH-1:0]             active_w;

   pwm_hl_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .time_q (time_q),
      .ctl_q  (ctl_q)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int DLSB = div_lsb(c);
      localparam int CEN  = clken_bit(c);
      localparam int REN  = run_bit(c);

      assign active_w[c] = ctl_q[CEN] && ctl_q[REN];

      pwm_hl_prescale #(.DIV_W(DIV_W)) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (active_w[c]),
         .div    (ctl_q[DLSB +: DIV_W]),
         .tick   (tick_w[c])
      );

      pwm_hl_wave #(.CNT_W(CNT_W)) u_wave (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (active_w[c]),
         .tick   (tick_w[c]),
         .hi_in  (time_q[c][HIGH_LSB +: CNT_W]),
         .lo_in  (time_q[c][LOW_LSB +: CNT_W]),
         .pwm    (pwm_o[c])
      );
   end
endmodule

// File: rtl/pwm_hl_chk.sv
module pwm_hl_chk #(
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rdata,
   input logic [1:0]        pwm_o,
   input logic [1:0]        tick_w,
   input logic [31:0]       ctl_q
);
   // R5
   ctl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(2) && !(wdata[15] && wdata[0])) |=> !pwm_o[0]);

   // R2
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(3)) |=> (rdata == 32'd0));

   // R2
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr < ADDR_W'(3)) ##1 (rd_en && !wr_en && addr == $past(addr))
      |=> (rdata == $past(wdata, 2)));

   // R4
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_w[0] && ctl_q[14:8] != 7'd0 && !(wr_en && addr == ADDR_W'(2)))
      |=> !tick_w[0]);
endmodule

bind pwm_hl_dual pwm_hl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .rd_en  (rd_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .pwm_o  (pwm_o),
   .tick_w (tick_w),
   .ctl_q  (ctl_q)
);

// File: tb/sim_pwm_hl_dual.sv
`timescale 1ns/1ps
module sim_pwm_hl_dual;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  pwm_o;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_hl_dual u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic logic expect_lvl(input int n, input int d, input int h, input int l);
      int p;
      p = h + l;
      if (p == 0) return 1'b0;
      return (((n / (d + 1)) % p) < h);
   endfunction

   function automatic logic [31:0] ctl_word(input int ch, input int d);
      return (32'(d) << (8 + 8 * ch)) | (32'd1 << (15 + 8 * ch)) | (32'd1 << ch);
   endfunction

   task automatic run_case(input int ch, input int d, input int h, input int l);
      logic [31:0] rb;
      string       tag;
      int          p, ns;
      p = h + l;
      if (p == 0 || h == 0 || l == 0) tag = "R7";
      else if (d > 0)                 tag = "R4";
      else                            tag = "R6";
      do_write(2'(ch), {16'(h), 16'(l)});
      do_read(2'(ch), rb);
      chk("R3", "timing readback", rb, {16'(h), 16'(l)});
      do_write(2'd2, ctl_word(ch, d));
      ns = (p == 0) ? 8 : 2 * p * (d + 1) + 2;
      for (int n = 0; n < ns; n++) begin
         chk(tag, $sformatf("ch%0d d=%0d h=%0d l=%0d n=%0d", ch, d, h, l, n),
             32'(pwm_o[ch]), 32'(expect_lvl(n, d, h, l)));
         chk("R9", "idle channel low", 32'(pwm_o[1-ch]), 32'd0);
         @(negedge clk);
      end
      do_write(2'd2, 32'd0);
      chk("R5", "outputs low after disable", 32'(pwm_o), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rb;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", "outputs after reset", 32'(pwm_o), 32'd0);
      for (int a = 0; a < 3; a++) begin
         do_read(2'(a), rb);
         chk("R1", $sformatf("word %0d after reset", a), rb, 32'd0);
      end

      // R2: read back written patterns, unmapped word
      do_write(2'd0, 32'h1234_ABCD);
      do_write(2'd1, 32'hFEDC_0123);
      do_write(2'd2, 32'h0055_AA00);
      do_write(2'd3, 32'hFFFF_FFFF);
      do_read(2'd0, rb); chk("R2", "word 0", rb, 32'h1234_ABCD);
      do_read(2'd1, rb); chk("R2", "word 1", rb, 32'hFEDC_0123);
      do_read(2'd2, rb); chk("R2", "word 2", rb, 32'h0055_AA00);
      do_read(2'd3, rb); chk("R2", "word 3", rb, 32'd0);
      repeat (3) @(negedge clk);
      chk("R2", "rdata holds without strobe", rdata, 32'd0);
      do_write(2'd2, 32'd0);
      chk("R5", "run bits clear, outputs low", 32'(pwm_o), 32'd0);

      // R5: only one of the two enables set
      do_write(2'd0, {16'd2, 16'd1});
      do_write(2'd2, 32'h0000_8000);
      for (int n = 0; n < 8; n++) begin
         chk("R5", "clock enable only", 32'(pwm_o[0]), 32'd0);
         @(negedge clk);
      end
      do_write(2'd2, 32'h0000_0001);
      for (int n = 0; n < 8; n++) begin
         chk("R5", "run enable only", 32'(pwm_o[0]), 32'd0);
         @(negedge clk);
      end
      do_write(2'd2, 32'd0);

      // R3/R4/R6/R7: sweep of small settings on both channels
      for (int ch = 0; ch < 2; ch++)
         for (int d = 0; d < 3; d++)
            for (int h = 0; h < 4; h += (h == 1) ? 2 : 1)
               for (int l = 0; l < 4; l += (l == 1) ? 2 : 1)
                  run_case(ch, d, h, l);
      run_case(0, 127, 1, 1);
      run_case(1, 127, 2, 1);

      // R8: timing change mid-period on channel B
      do_write(2'd1, {16'd2, 16'd1});
      do_write(2'd2, ctl_word(1, 1));
      for (int n = 0; n < 18; n++) begin
         logic e;
         e = (n < 6) ? expect_lvl(n, 1, 2, 1) : expect_lvl(n - 6, 1, 1, 2);
         chk("R8", $sformatf("shadowed update n=%0d", n), 32'(pwm_o[1]), 32'(e));
         if (n == 1) begin
            wr_en = 1'b1; addr = 2'd1; wdata = {16'd1, 16'd2};
         end
         @(negedge clk);
         if (n == 1) wr_en = 1'b0;
      end
      do_write(2'd2, 32'd0);

      // R9: both channels running together with different settings
      do_write(2'd0, {16'd2, 16'd3});
      do_write(2'd1, {16'd1, 16'd1});
      do_write(2'd2, ctl_word(0, 0) | ctl_word(1, 2));
      for (int n = 0; n < 24; n++) begin
         chk("R9", $sformatf("A concurrent n=%0d", n), 32'(pwm_o[0]), 32'(expect_lvl(n, 0, 2, 3)));
         chk("R9", $sformatf("B concurrent n=%0d", n), 32'(pwm_o[1]), 32'(expect_lvl(n, 2, 1, 1)));
         @(negedge clk);
      end
      do_write(2'd2, ctl_word(1, 2));
      chk("R9", "A stopped", 32'(pwm_o[0]), 32'd0);
      do_write(2'd2, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule